// File: doc/BRIEF.md
# Pulse-Interval Downlink Symbol Modulator

This block drives the carrier-enable line of a low-frequency reader so that the reader can send downlink symbols to a passive tag. Each symbol has two parts. First the carrier stays on for a number of periods, and that number encodes the value. Then the carrier drops for a fixed gap. A command source hands over one item at a time on a valid/ready handshake. An item is a data symbol, a start gap (carrier off only) or a long reference pulse.

A 2-bit profile input selects one of four timing sets: normal, long-reference, leading-zero and one-of-four. In the one-of-four profile each symbol carries two bits, and the on-time grows in equal steps with the value. A clock-enable tick paces all timing, one tick per carrier period. While no item is in progress the carrier stays on so that the tag keeps its power.

Top module: `ldm_modulator`

## Requirements
- R1: After reset, and whenever no item is in progress, `sym_ready_o` is 1 and `carrier_o` is 1. An asynchronous reset during an item returns the block to this state.
- R2: An item is accepted on a clock edge where `sym_valid_i` and `sym_ready_o` are both 1. `sym_ready_o` then stays 0 until the carrier-off gap of that item has ended. It returns to 1 on the tick that ends the gap.
- R3: `carrier_o` changes only on edges where `tick_i` is 1. The item starts on the first tick after acceptance, and `carrier_o` stays 1 before that tick.
- R4: Profile `mode_i`=00 (normal), data item: the on-time is 18 ticks when `sym_val_i[0]`=0 and 50 ticks when it is 1. The gap is NORM_GAP ticks (default 10). With the first tick after acceptance counted as tick 1, the carrier falls at tick 1+on and rises at tick 1+on+gap.
- R5: Profile 01 (long-reference) times data items exactly as profile 00 does.
- R6: Profile 10 (leading-zero), data item: the on-time is 18 ticks for value 0 and 40 ticks for value 1. The gap is 20 ticks.
- R7: Profile 11 (one-of-four), data item: the on-time is 18+16·v ticks, where v = `sym_val_i[1:0]`. This gives 18, 34, 50 and 66. The gap is 20 ticks.
- R8: `kind_i`=01 (start gap): there is no on-time. The carrier falls at tick 1 and stays off for 15 ticks under profiles 00/01, or 31 ticks under profiles 10/11.
- R9: `kind_i`=10 (reference pulse), under any profile: the on-time is 154 ticks and the gap is NORM_GAP ticks.
- R10: `kind_i`=11 is timed as a data item (`kind_i`=00).
- R11: The profile, kind and value are captured at acceptance. Changes on those inputs while an item is in progress have no effect on it.
- R12: Under profiles 00, 01 and 10, `sym_val_i[1]` has no effect on timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse per carrier period |
| mode_i | input | 2 | Timing profile: 00 normal, 01 long-reference, 10 leading-zero, 11 one-of-four |
| kind_i | input | 2 | Item kind: 00 data, 01 start gap, 10 reference pulse, 11 data |
| sym_val_i | input | 2 | Symbol value (bit 0 only in 1-bit profiles) |
| sym_valid_i | input | 1 | Item offered |
| sym_ready_o | output | 1 | Block idle, item can be accepted |
| carrier_o | output | 1 | Carrier enable to the field driver |

## Verification
The assertions check four properties on every cycle: the carrier stays on while the block is ready, the carrier never moves without a tick, ready drops right after acceptance, and the captured command holds steady while an item is in progress. They also check that the phase counter never reaches zero inside a timed phase and that a falling edge comes only from an on-phase or an armed item. The exact on-time and gap length of every profile, kind and value combination can only be shown by the bench. It sweeps all 64 combinations, counts ticks to the falling edge and to the return of ready, and changes the inputs during each item. The bench also shows recovery from a reset applied in the middle of an item.

// File: rtl/ldm_pkg.sv
package ldm_pkg;
  localparam int SYM_W   = 2;
  localparam int NUM_SYM = 1 << SYM_W;

  typedef enum logic [1:0] {
    MODE_NORM    = 2'b00,
    MODE_LONGREF = 2'b01,
    MODE_LZERO   = 2'b10,
    MODE_QUAD    = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    KIND_DATA  = 2'b00,
    KIND_START = 2'b01,
    KIND_REF   = 2'b10,
    KIND_DATA2 = 2'b11
  } kind_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_ARM  = 2'b01,
    PH_ON   = 2'b10,
    PH_OFF  = 2'b11
  } phase_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/ldm_timing.sv
module ldm_timing
  import ldm_pkg::*;
#(
  parameter int BASE_ON     = 18,
  parameter int NORM_ONE_ON = 50,
  parameter int LZ_ONE_ON   = 40,
  parameter int QUAD_STEP   = 16,
  parameter int REF_ON      = 154,
  parameter int NORM_GAP    = 10,
  parameter int NORM_START  = 15,
  parameter int WIDE_GAP    = 20,
  parameter int WIDE_START  = 31,
  parameter int CNT_W       = 8
) (
  input  mode_e              mode_i,
  input  kind_e              kind_i,
  input  logic [SYM_W-1:0]   val_i,
  output logic [CNT_W-1:0]   on_len_o,
  output logic [CNT_W-1:0]   off_len_o,
  output logic               skip_on_o
);
  localparam logic [CNT_W-1:0] L_BASE   = CNT_W'(BASE_ON);
  localparam logic [CNT_W-1:0] L_N1     = CNT_W'(NORM_ONE_ON);
  localparam logic [CNT_W-1:0] L_LZ1    = CNT_W'(LZ_ONE_ON);
  localparam logic [CNT_W-1:0] L_REF    = CNT_W'(REF_ON);
  localparam logic [CNT_W-1:0] L_NGAP   = CNT_W'(NORM_GAP);
  localparam logic [CNT_W-1:0] L_NSTART = CNT_W'(NORM_START);
  localparam logic [CNT_W-1:0] L_WGAP   = CNT_W'(WIDE_GAP);
  localparam logic [CNT_W-1:0] L_WSTART = CNT_W'(WIDE_START);

  // one-of-four on-times, evenly stepped from the base width
  logic [CNT_W-1:0] quad_on [NUM_SYM];
  for (genvar g = 0; g < NUM_SYM; g++) begin : g_quad
    assign quad_on[g] = CNT_W'(BASE_ON + g * QUAD_STEP);
  end

  logic wide;
  assign wide = (mode_i == MODE_LZERO) || (mode_i == MODE_QUAD);

  always_comb begin
    skip_on_o = 1'b0;
    on_len_o  = L_BASE;
    off_len_o = wide ? L_WGAP : L_NGAP;
    case (kind_i)
      KIND_START: begin
        skip_on_o = 1'b1;
        off_len_o = wide ? L_WSTART : L_NSTART;
      end
      KIND_REF: begin
        on_len_o  = L_REF;
        off_len_o = L_NGAP;
      end
      default: begin
        case (mode_i)
          MODE_LZERO: on_len_o = val_i[0] ? L_LZ1 : L_BASE;
          MODE_QUAD:  on_len_o = quad_on[val_i];
          default:    on_len_o = val_i[0] ? L_N1 : L_BASE;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/ldm_seq.sv
module ldm_seq
  import ldm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             go_i,
  input  logic             skip_on_i,
  input  logic [CNT_W-1:0] on_len_i,
  input  logic [CNT_W-1:0] off_len_i,
  output logic             carrier_o,
  output logic             busy_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             carrier_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_IDLE;
      cnt_q     <= '0;
      carrier_q <= 1'b1;
    end else begin
      case (phase_q)
        PH_IDLE: if (go_i) phase_q <= PH_ARM;
        PH_ARM: if (tick_i) begin
          if (skip_on_i) begin
            carrier_q <= 1'b0;
            cnt_q     <= off_len_i;
            phase_q   <= PH_OFF;
          end else begin
            carrier_q <= 1'b1;
            cnt_q     <= on_len_i;
            phase_q   <= PH_ON;
          end
        end
        PH_ON: if (tick_i) begin
          if (cnt_q == ONE) begin
            carrier_q <= 1'b0;
            cnt_q     <= off_len_i;
            phase_q   <= PH_OFF;
          end else begin
            cnt_q <= cnt_q - ONE;
          end
        end
        PH_OFF: if (tick_i) begin
          if (cnt_q == ONE) begin
            carrier_q <= 1'b1;
            cnt_q     <= '0;
            phase_q   <= PH_IDLE;
          end else begin
            cnt_q <= cnt_q - ONE;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign carrier_o = carrier_q;
  assign busy_o    = (phase_q != PH_IDLE);

  // R3: carrier moves only on tick edges
  p_tick_only_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(carrier_o));
  // R3: no carrier drop before the first tick of an item
  p_arm_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_ARM) |-> carrier_o);
  // R2: timed phases never hold an exhausted count
  p_cnt_live_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_ON || phase_q == PH_OFF) |-> (cnt_q != '0));
  // R4: a falling edge comes only from an on-phase or an armed item
  p_fall_src_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(carrier_o) |-> ($past(phase_q) == PH_ON || $past(phase_q) == PH_ARM));
endmodule

// File: rtl/ldm_modulator.sv
module ldm_modulator
  import ldm_pkg::*;
#(
  parameter int BASE_ON     = 18,
  parameter int NORM_ONE_ON = 50,
  parameter int LZ_ONE_ON   = 40,
  parameter int QUAD_STEP   = 16,
  parameter int REF_ON      = 154,
  parameter int NORM_GAP    = 10,
  parameter int NORM_START  = 15,
  parameter int WIDE_GAP    = 20,
  parameter int WIDE_START  = 31
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [1:0] mode_i,
  input  logic [1:0] kind_i,
  input  logic [1:0] sym_val_i,
  input  logic       sym_valid_i,
  output logic       sym_ready_o,
  output logic       carrier_o
);
  localparam int MAX_LEN = imax(imax(imax(REF_ON, BASE_ON + (NUM_SYM - 1) * QUAD_STEP),
                                     imax(NORM_ONE_ON, LZ_ONE_ON)),
                                imax(imax(NORM_GAP, NORM_START), imax(WIDE_GAP, WIDE_START)));
  localparam int CNT_W = $clog2(MAX_LEN + 1);

  mode_e            mode_q;
  kind_e            kind_q;
  logic [SYM_W-1:0] val_q;
  logic             accept, busy;
  logic [CNT_W-1:0] on_len, off_len;
  logic             skip_on;

  assign accept      = sym_valid_i && sym_ready_o;
  assign sym_ready_o = !busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_NORM;
      kind_q <= KIND_DATA;
      val_q  <= '0;
    end else if (accept) begin
      mode_q <= mode_e'(mode_i);
      kind_q <= kind_e'(kind_i);
      val_q  <= sym_val_i;
    end
  end

  ldm_timing #(
    .BASE_ON(BASE_ON), .NORM_ONE_ON(NORM_ONE_ON), .LZ_ONE_ON(LZ_ONE_ON),
    .QUAD_STEP(QUAD_STEP), .REF_ON(REF_ON), .NORM_GAP(NORM_GAP),
    .NORM_START(NORM_START), .WIDE_GAP(WIDE_GAP), .WIDE_START(WIDE_START),
    .CNT_W(CNT_W)
  ) u_timing (
    .mode_i(mode_q), .kind_i(kind_q), .val_i(val_q),
    .on_len_o(on_len), .off_len_o(off_len), .skip_on_o(skip_on)
  );

  ldm_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .go_i(accept),
    .skip_on_i(skip_on), .on_len_i(on_len), .off_len_i(off_len),
    .carrier_o(carrier_o), .busy_o(busy)
  );

  // R1: tag stays powered while idle
  p_idle_high_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_ready_o |-> carrier_o);
  // R2: acceptance closes the handshake
  p_ready_drop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_valid_i && sym_ready_o) |=> !sym_ready_o);
  // R11: captured command frozen during an item
  p_hold_cmd_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sym_ready_o |=> ($stable(mode_q) && $stable(kind_q) && $stable(val_q)));
endmodule

// File: tb/sim_ldm_modulator.sv
module sim_ldm_modulator;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic [1:0] mode_i = '0;
  logic [1:0] kind_i = '0;
  logic [1:0] sym_val_i = '0;
  logic       sym_valid_i = 1'b0;
  logic       sym_ready_o, carrier_o;

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  always #5 clk_i = ~clk_i;

  ldm_modulator u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .mode_i(mode_i),
    .kind_i(kind_i), .sym_val_i(sym_val_i), .sym_valid_i(sym_valid_i),
    .sym_ready_o(sym_ready_o), .carrier_o(carrier_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_on(input int m, input int k, input int v);
    if (k == 2) return 154;
    case (m)
      2: return (v & 1) ? 40 : 18;
      3: return 18 + 16 * v;
      default: return (v & 1) ? 50 : 18;
    endcase
  endfunction

  function automatic int exp_gap(input int m, input int k);
    if (k == 1) return (m >= 2) ? 31 : 15;
    if (k == 2) return 10;
    return (m >= 2) ? 20 : 10;
  endfunction

  function automatic string tag_of(input int m, input int k, input int v);
    string t;
    if (k == 1) t = "R8";
    else if (k == 2) t = "R9";
    else if (m == 0) t = "R4";
    else if (m == 1) t = "R5";
    else if (m == 2) t = "R6";
    else t = "R7";
    if (k == 3) t = {t, "/R10"};
    if (m < 3 && v >= 2 && k != 1 && k != 2) t = {t, "/R12"};
    return $sformatf("%s/R11 m=%0d k=%0d v=%0d", t, m, k, v);
  endfunction

  task automatic run_item(input int m, input int k, input int v);
    int fall_at = 0;
    int rise_at = -1;
    int bounce  = 0;
    int f_exp, r_exp;
    string t;
    t = tag_of(m, k, v);
    @(negedge clk_i);
    chk({"R1 ready before ", t}, sym_ready_o, 1);
    mode_i = 2'(m); kind_i = 2'(k); sym_val_i = 2'(v); sym_valid_i = 1'b1;
    @(negedge clk_i);
    sym_valid_i = 1'b0;
    mode_i = ~2'(m); kind_i = ~2'(k); sym_val_i = ~2'(v);  // R11 scramble
    chk({"R2 ready low ", t}, sym_ready_o, 0);
    chk({"R3 carrier held ", t}, carrier_o, 1);
    for (int n = 1; n <= 400; n++) begin
      @(negedge clk_i); tick_i = 1'b1;
      @(negedge clk_i); tick_i = 1'b0;
      if (fall_at == 0 && !carrier_o) fall_at = n;
      else if (fall_at != 0 && carrier_o && !sym_ready_o) bounce++;
      if (sym_ready_o) begin rise_at = n; break; end
    end
    f_exp = (k == 1) ? 1 : 1 + exp_on(m, k, v);
    r_exp = f_exp + exp_gap(m, k);
    chk({"fall tick ", t}, fall_at, f_exp);
    chk({"R2 ready tick ", t}, rise_at, r_exp);
    chk({"gap unbroken ", t}, bounce, 0);
    chk({"R1 carrier idle ", t}, carrier_o, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 reset ready", sym_ready_o, 1);
    chk("R1 reset carrier", carrier_o, 1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 post-reset ready", sym_ready_o, 1);
    chk("R3 idle no ticks", carrier_o, 1);

    for (int m = 0; m < 4; m++)
      for (int k = 0; k < 4; k++)
        for (int v = 0; v < 4; v++)
          run_item(m, k, v);

    // R1: reset in the middle of a reference pulse's gap
    @(negedge clk_i);
    mode_i = 2'b00; kind_i = 2'b10; sym_val_i = 2'b00; sym_valid_i = 1'b1;
    @(negedge clk_i); sym_valid_i = 1'b0;
    for (int n = 0; n < 160; n++) begin
      @(negedge clk_i); tick_i = 1'b1;
      @(negedge clk_i); tick_i = 1'b0;
    end
    chk("R1 mid-gap carrier off", carrier_o, 0);
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R1 mid-item reset ready", sym_ready_o, 1);
    chk("R1 mid-item reset carrier", carrier_o, 1);
    rst_ni = 1'b1;
    run_item(3, 0, 3);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    while (!done) begin
      @(posedge clk_i);
      cycles++;
      if (cycles > 150000 && !done) begin
        vectors++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=0", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
      end
    end
  end
endmodule